// File: doc/BRIEF.md
# Orbit Pulse Conditioning Channel

This block rebuilds a once-per-turn orbit marker inside the bunch-clock domain. The marker comes either from an external logic-level pulse, which is synchronized and reduced to its rising edge, or from a free-running internal generator with a programmable period. The chosen marker is then shifted by a programmable coarse delay and stretched to a programmable width. Both settings are counted in bunch-clock cycles and are limited to one 3564-bucket turn.

Two counters run alongside the pulse path. One is a live 12-bit bunch counter that restarts at every orbit marker. The other is a 32-bit orbit counter that advances once per marker and can be zeroed by a strobe. Software reads both. The analog front end, the sub-nanosecond delay lines and the output drivers sit outside this block.

Top module: `orbit_cond_top`

## Requirements
- R1: `src_sel` picks the marker source: 1 selects the internal generator, 0 selects the external input. Markers from the unselected source have no effect on any output.
- R2: The external input passes through two flops. A marker is taken only on a rising edge. A 0-to-1 change sampled at clock edge k acts as a marker at edge k+2. An input held high yields exactly one marker.
- R3: The internal generator produces a marker every P cycles, where P is `period_cfg` and runs freely whichever source is selected. A period of 0 acts as 1.
- R4: `bunch_cnt` becomes 0 at every marker edge and otherwise adds 1 per cycle, wrapping modulo 4096.
- R5: With an effective delay D, a marker at edge n raises `orbit_out` after edge n+D. D is `delay_cfg`, clamped to 3563, and 0 means no delay.
- R6: `orbit_out` stays high for W cycles, where W is `width_cfg` clamped to 3563, and a width of 0 gives W=1. A new start while the pulse is high reloads the full width.
- R7: A marker that arrives while a delayed start is pending discards that start and restarts the delay from the new marker.
- R8: `orbit_count` adds 1 at every selected marker and wraps modulo 2^32.
- R9: `cnt_clear` zeroes `orbit_count` at the next edge and takes priority over a marker at the same edge.
- R10: While reset is held, and at the first check after it, `orbit_out` is 0 and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| orbit_raw | input | 1 | External orbit pulse at logic level (asynchronous) |
| src_sel | input | 1 | Source select: 1 internal, 0 external |
| period_cfg | input | 12 | Internal orbit period in bunch cycles |
| delay_cfg | input | 12 | Coarse delay in bunch cycles |
| width_cfg | input | 12 | Output pulse width in bunch cycles |
| cnt_clear | input | 1 | Strobe that zeroes the orbit counter |
| orbit_out | output | 1 | Conditioned orbit pulse |
| bunch_cnt | output | 12 | Bunch clocks since the last marker |
| orbit_count | output | 32 | Number of markers seen |

## Verification
Timing counts from the edge at which a marker acts inside the block. An external rise sampled at edge k acts at edge k+2, while an internal marker acts at the edge where its period ends. `bunch_cnt` and `orbit_count` reflect a marker right after that same edge. `orbit_out` rises D edges later and falls W edges after it rises. The reference model counts clock edges itself. Inputs are driven on the falling edge and all three outputs are compared on the next falling edge, so every register stage is accounted for. Targeted checks cover the clamped delay and width extremes, the restart case in which a pending pulse never appears, and a clear that coincides with a marker.

// File: rtl/orbit_cond_pkg.sv
package orbit_cond_pkg;

  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } orbit_src_e;

  // Effective coarse delay: saturate at the last bucket of a turn.
  function automatic int unsigned eff_delay(input int unsigned raw, input int unsigned last);
    return (raw > last) ? last : raw;
  endfunction

  // Effective width: at least one cycle, at most the last bucket of a turn.
  function automatic int unsigned eff_width(input int unsigned raw, input int unsigned last);
    if (raw == 0) return 1;
    return (raw > last) ? last : raw;
  endfunction

  // Effective internal period: zero behaves like one.
  function automatic int unsigned eff_period(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

endpackage

// File: rtl/orbit_edge_sync.sv
module orbit_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic rise_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[DEPTH-2:0], raw_in};
  end

  // Rising edge seen at the output of the last synchronizer flop.
  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];

  // R2: an accepted rise lasts one cycle only
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/orbit_int_gen.sv
module orbit_int_gen
  import orbit_cond_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_cfg,
  output logic             tick_o
);
  logic [CNT_W-1:0] phase;
  int unsigned      per_eff;

  always_comb begin
    per_eff = eff_period(int'(period_cfg));
    tick_o  = (32'(phase) + 32'd1) >= per_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      phase <= '0;
    else if (tick_o) phase <= '0;
    else             phase <= phase + 1'b1;
  end

  // R3: the phase restarts after each internal marker
  a_r3_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (phase == '0));

endmodule

// File: rtl/orbit_retimer.sv
module orbit_retimer
  import orbit_cond_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int TURN_N = 3564
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] delay_cfg,
  input  logic [CNT_W-1:0] width_cfg,
  output logic             start_o,
  output logic             pulse_o
);
  localparam int unsigned LAST = TURN_N - 1;

  logic [CNT_W-1:0] dly_eff, wid_eff;
  logic [CNT_W-1:0] dcnt, wcnt;
  logic             pend;

  always_comb begin
    dly_eff = CNT_W'(eff_delay(int'(delay_cfg), LAST));
    wid_eff = CNT_W'(eff_width(int'(width_cfg), LAST));
    start_o = (evt_i && dly_eff == '0) || (!evt_i && pend && dcnt == '0);
  end

  // Delay stage: a new marker always reloads the countdown.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      dcnt <= '0;
    end else if (evt_i) begin
      pend <= (dly_eff != '0);
      dcnt <= (dly_eff != '0) ? dly_eff - 1'b1 : '0;
    end else if (pend) begin
      if (dcnt == '0) pend <= 1'b0;
      else            dcnt <= dcnt - 1'b1;
    end
  end

  // Width stage: a start reloads the full width.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_o <= 1'b0;
      wcnt    <= '0;
    end else if (start_o) begin
      pulse_o <= 1'b1;
      wcnt    <= wid_eff - 1'b1;
    end else if (pulse_o) begin
      if (wcnt == '0) pulse_o <= 1'b0;
      else            wcnt    <= wcnt - 1'b1;
    end
  end

  // R6: a start always drives the output high on the next cycle
  a_r6_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> pulse_o);

  // R7: a marker with a delay above one restarts the countdown
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && dly_eff > 1) |=> (pend && dcnt == $past(dly_eff) - 1'b1));

  // R5: no start while the countdown is still running
  a_r5_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && dcnt != '0 && !evt_i) |-> !start_o);

endmodule

// File: rtl/orbit_counters.sv
module orbit_counters #(
  parameter int CNT_W = 12,
  parameter int ORB_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] bunch_o,
  output logic [ORB_W-1:0] orbits_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     bunch_o <= '0;
    else if (evt_i) bunch_o <= '0;
    else            bunch_o <= bunch_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       orbits_o <= '0;
    else if (clear_i) orbits_o <= '0;
    else if (evt_i)   orbits_o <= orbits_o + 1'b1;
  end

  // R4: bunch counter restarts on a marker
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> (bunch_o == '0));

  // R4: bunch counter advances by one between markers
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i |=> (bunch_o == CNT_W'($past(bunch_o) + 1'b1)));

  // R8: one increment per marker
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !clear_i) |=> (orbits_o == ORB_W'($past(orbits_o) + 1'b1)));

  // R9: clear wins over a marker
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (orbits_o == '0));

endmodule

// File: rtl/orbit_cond_top.sv
module orbit_cond_top
  import orbit_cond_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int ORB_W     = 32,
  parameter int TURN_N    = 3564,
  parameter int SYNC_FLOP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             orbit_raw,
  input  logic             src_sel,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [CNT_W-1:0] delay_cfg,
  input  logic [CNT_W-1:0] width_cfg,
  input  logic             cnt_clear,
  output logic             orbit_out,
  output logic [CNT_W-1:0] bunch_cnt,
  output logic [ORB_W-1:0] orbit_count
);
  logic ext_evt, int_evt, sel_evt, start_evt;

  orbit_edge_sync #(.STAGES(SYNC_FLOP)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(orbit_raw), .rise_o(ext_evt)
  );

  orbit_int_gen #(.CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg), .tick_o(int_evt)
  );

  assign sel_evt = (orbit_src_e'(src_sel) == SRC_INT) ? int_evt : ext_evt;

  orbit_retimer #(.CNT_W(CNT_W), .TURN_N(TURN_N)) u_retime (
    .clk(clk), .rst_n(rst_n), .evt_i(sel_evt),
    .delay_cfg(delay_cfg), .width_cfg(width_cfg),
    .start_o(start_evt), .pulse_o(orbit_out)
  );

  orbit_counters #(.CNT_W(CNT_W), .ORB_W(ORB_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .evt_i(sel_evt), .clear_i(cnt_clear),
    .bunch_o(bunch_cnt), .orbits_o(orbit_count)
  );

  // R1: the selected source alone drives the marker
  a_r1_int_only: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && !int_evt) |-> !sel_evt);
  a_r1_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_sel && !ext_evt) |-> !sel_evt);

  // R10: output low out of reset
  a_r10_reset: assert property (@(posedge clk)
    !rst_n |=> !orbit_out);

endmodule

// File: tb/orbit_cond_top_tb_top.sv
module orbit_cond_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAST_BKT   = 3563;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        orbit_raw = 1'b0;
  logic        src_sel = 1'b0;
  logic [11:0] period_cfg = 12'd10;
  logic [11:0] delay_cfg = '0;
  logic [11:0] width_cfg = '0;
  logic        cnt_clear = 1'b0;
  logic        orbit_out;
  logic [11:0] bunch_cnt;
  logic [31:0] orbit_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  orbit_cond_top dut_i (
    .clk(clk), .rst_n(rst_n), .orbit_raw(orbit_raw), .src_sel(src_sel),
    .period_cfg(period_cfg), .delay_cfg(delay_cfg), .width_cfg(width_cfg),
    .cnt_clear(cnt_clear), .orbit_out(orbit_out), .bunch_cnt(bunch_cnt),
    .orbit_count(orbit_count)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    finished = 0;
  string cur_req = "R10";

  // ---------------- reference model ----------------
  bit          samples[$];
  int          since_int;
  int          edge_no;
  int          fire_at, hold_until;
  int          m_bunch;
  logic [31:0] m_orbits;
  bit          m_out;
  int          rises, high_cycles;
  bit          prev_out;

  function automatic int clamp_d(int v); return (v > LAST_BKT) ? LAST_BKT : v; endfunction
  function automatic int clamp_w(int v); return (v == 0) ? 1 : ((v > LAST_BKT) ? LAST_BKT : v); endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      samples = '{1'b0, 1'b0, 1'b0};
      since_int = 0; edge_no = 0; fire_at = -1; hold_until = -1;
      m_bunch = 0; m_orbits = '0; m_out = 1'b0;
    end else begin
      bit ext_m, int_m, evt_m;
      int per;
      edge_no++;
      // external rise sampled two edges ago, preceded by a low sample
      ext_m = samples[$-1] && !samples[$-2];
      per   = (period_cfg == 0) ? 1 : int'(period_cfg);
      int_m = (since_int + 1) >= per;
      evt_m = src_sel ? int_m : ext_m;
      samples.push_back(orbit_raw);
      if (samples.size() > 6) void'(samples.pop_front());
      since_int = int_m ? 0 : since_int + 1;
      m_bunch   = evt_m ? 0 : (m_bunch + 1) % 4096;
      if (cnt_clear) m_orbits = '0;
      else if (evt_m) m_orbits = m_orbits + 1;
      if (evt_m) fire_at = edge_no + clamp_d(int'(delay_cfg));
      if (fire_at == edge_no) begin
        hold_until = edge_no + clamp_w(int'(width_cfg)) - 1;
        fire_at = -1;
      end
      m_out = (edge_no <= hold_until);
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL [%s] %s act=%0d exp=%0d", cur_req, what, act, exp);
    end
  endtask

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(orbit_out == m_out, "orbit_out", orbit_out, m_out);
      check(bunch_cnt == 12'(m_bunch), "bunch_cnt", bunch_cnt, m_bunch);
      check(orbit_count == m_orbits, "orbit_count", orbit_count, m_orbits);
      if (orbit_out && !prev_out) rises++;
      if (orbit_out) high_cycles++;
      prev_out = orbit_out;
    end
  end

  task automatic wait_cycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic ext_pulse(input int len);
    orbit_raw = 1'b1; wait_cycles(len); orbit_raw = 1'b0;
  endtask

  initial begin
    wait_cycles(4);
    // R10: reset state
    check(orbit_out == 1'b0, "R10 out in reset", orbit_out, 0);
    check(bunch_cnt == '0 && orbit_count == '0, "R10 counters in reset", orbit_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(orbit_out == 1'b0, "R10 out after reset", orbit_out, 0);

    // R2 R5 R6: external source, no delay, minimum width
    cur_req = "R1 R2 R5 R6 R8";
    src_sel = 1'b0; delay_cfg = 12'd0; width_cfg = 12'd0;
    ext_pulse(3); wait_cycles(20);
    delay_cfg = 12'd5; width_cfg = 12'd3;
    ext_pulse(2); wait_cycles(20);
    // R2: held-high input counts once
    cur_req = "R2 R8";
    rises = 0;
    ext_pulse(40); wait_cycles(20);
    check(rises == 1, "R2 one pulse for held input", rises, 1);

    // R1 R3: internal source; external activity must be ignored
    cur_req = "R1 R3 R4 R5 R6";
    src_sel = 1'b1; period_cfg = 12'd10; delay_cfg = 12'd3; width_cfg = 12'd4;
    wait_cycles(15); ext_pulse(3); wait_cycles(45);
    // R3: period 0 behaves as 1, delay 0 -> output continuously high
    cur_req = "R3 R6";
    period_cfg = 12'd0; delay_cfg = 12'd0; width_cfg = 12'd1;
    wait_cycles(12);
    check(orbit_out == 1'b1, "R3 period zero keeps output high", orbit_out, 1);

    // R7: markers every 5 cycles with delay 8 -> the pulse never comes
    cur_req = "R7";
    period_cfg = 12'd5; delay_cfg = 12'd8; width_cfg = 12'd2;
    wait_cycles(20); rises = 0; wait_cycles(100);
    check(rises == 0, "R7 restarted delay never fires", rises, 0);

    // R9: clear held across markers
    cur_req = "R9 R8";
    cnt_clear = 1'b1; wait_cycles(12); cnt_clear = 1'b0;
    check(orbit_count == '0, "R9 cleared count", orbit_count, 0);
    wait_cycles(20);

    // R4: long idle on external source -> bunch counter wraps
    cur_req = "R4 R1";
    src_sel = 1'b0; delay_cfg = 12'd0; width_cfg = 12'd0;
    wait_cycles(4200);

    // R5: delay beyond a turn clamps to 3563
    cur_req = "R5";
    delay_cfg = 12'd4000; width_cfg = 12'd1; rises = 0;
    ext_pulse(1); wait_cycles(3600);
    check(rises == 1, "R5 clamped delay pulse", rises, 1);

    // R6: width beyond a turn clamps to 3563
    cur_req = "R6";
    delay_cfg = 12'd0; width_cfg = 12'd4000; high_cycles = 0;
    ext_pulse(1); wait_cycles(3600);
    check(high_cycles == LAST_BKT, "R6 clamped width", high_cycles, LAST_BKT);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL [watchdog] run did not complete act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule